// File: doc/BRIEF.md
# Single-Wire Ratio-Coded Frame Decoder

This block listens to a one-wire, open-drain control line and turns two-byte frames into register writes. Each bit is coded by the ratio of its two phases rather than by a fixed time slot. Every bit starts with a falling edge and has a low phase followed by a high phase. When the high phase lasts at least twice the low phase the bit is a 1. When the low phase lasts at least twice the high phase the bit is a 0. Any bit that meets neither rule cancels the frame. A byte opens after the line has been high for a minimum time. It closes when the line stays low for a minimum time after the eighth bit. Bits arrive most significant first.

The first byte of a frame must equal a fixed device code (default 8'b0111_0011). The second byte is the command. Its bit 7 asks for an acknowledge, bits 6:5 give a 2-bit register address, and bits 4:0 carry a 5-bit value. A good frame produces a one-cycle write strobe together with the address and value. If an acknowledge was asked for, the block waits for the sender to release the line and then pulls the line low for a fixed number of cycles. All timings are parameters counted in clock cycles. The line input passes through a synchronizer inside the block.

Top module: `swire_frame_decoder`

## Requirements
- R1: After reset, `wr_valid` and `ack_pull` are 0.
- R2: A bit decodes as 1 when its high phase is at least twice its low phase, with the low phase in [T_MIN, T_MAX]. A bit decodes as 0 when its low phase is at least twice its high phase, with the high phase in [T_MIN, T_MAX]. The longer phase may be up to 2*T_MAX. Bits are shifted in MSB first.
- R3: A bit whose longer phase is less than twice its shorter phase aborts the frame, and no strobe follows.
- R4: A bit whose shorter phase is below T_MIN aborts the frame. So does any bit phase longer than 2*T_MAX.
- R5: The first byte must equal DEV_ADDR. If it does not, the frame gives neither a strobe nor an acknowledge.
- R6: A byte ends once the line has been low for END_MIN cycles after its eighth bit. At the end of the second byte, `wr_valid` pulses for exactly one cycle, with `wr_addr` = byte bit 6:5 and `wr_data` = byte bit 4:0.
- R7: When bit 7 of the second byte is 1, `ack_pull` rises only after the line has been released high for ACK_DLY cycles. It then stays high for exactly ACK_LEN cycles. When bit 7 is 0, `ack_pull` stays 0.
- R8: After an aborted frame, the next well-formed frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level of the shared wire (asynchronous) |
| wr_valid | output | 1 | One-cycle strobe for a decoded command |
| wr_addr | output | 2 | Register address of the command |
| wr_data | output | 5 | Data value of the command |
| ack_pull | output | 1 | 1 = pull the wire low (open-drain acknowledge) |

## Verification
Valid frames are sent with random phase lengths and random command bytes, drawn from the full legal range of short and long phases. This shows that decoding depends on the ratio of the phases and not on their absolute length. Directed frames sit exactly on the limits: the shortest legal phases with a ratio of exactly two, and the longest legal phases. These show that the comparisons include the boundary values. Three kinds of corrupted last bit are sent: a ratio just under two, a short phase below the minimum, and an over-long phase. A wrong device code is also sent. Each case must be rejected, and each is followed by a clean frame to show that decoding recovers. Frames with and without the acknowledge request separate the pull-down timing from the strobe path.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_HIGH,
    S_END,
    S_ACK
  } swire_state_e;

  typedef enum logic [1:0] {
    A_OFF,
    A_WAIT,
    A_DRIVE
  } ack_phase_e;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= {s_q[STAGES-2:0], d};
      end
      assign q = s_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/swire_bit_classify.sv
module swire_bit_classify #(
  parameter int W     = 8,
  parameter int T_MIN = 4,
  parameter int T_MAX = 60
) (
  input  logic [W-1:0] lo_len,
  input  logic [W-1:0] hi_len,
  output logic         bit_ok,
  output logic         bit_val
);
  localparam logic [W:0] MIN_C  = (W+1)'(T_MIN);
  localparam logic [W:0] MAX_C  = (W+1)'(T_MAX);
  localparam logic [W:0] LONG_C = (W+1)'(2 * T_MAX);

  logic [W:0] lo_w, hi_w, lo_x2, hi_x2;
  logic       is_one, is_zero;

  always_comb begin
    lo_w    = {1'b0, lo_len};
    hi_w    = {1'b0, hi_len};
    lo_x2   = {lo_len, 1'b0};
    hi_x2   = {hi_len, 1'b0};
    is_one  = (hi_w >= lo_x2) && (lo_w >= MIN_C) && (lo_w <= MAX_C) && (hi_w <= LONG_C);
    is_zero = (lo_w >= hi_x2) && (hi_w >= MIN_C) && (hi_w <= MAX_C) && (lo_w <= LONG_C);
    bit_ok  = is_one || is_zero;
    bit_val = is_one;
  end
endmodule

// File: rtl/swire_ack_timer.sv
module swire_ack_timer
  import swire_pkg::*;
#(
  parameter int ACK_DLY = 4,
  parameter int ACK_LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic line_hi,
  output logic pull,
  output logic done
);
  localparam int TOP = (ACK_LEN > ACK_DLY) ? ACK_LEN : ACK_DLY;
  localparam int CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] DLY_END = CW'(ACK_DLY - 1);
  localparam logic [CW-1:0] LEN_END = CW'(ACK_LEN - 1);

  ack_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (phase_q)
      A_WAIT: begin
        if (!line_hi) begin
          cnt_d = '0;
        end else if (cnt_q == DLY_END) begin
          cnt_d   = '0;
          phase_d = A_DRIVE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      A_DRIVE: begin
        if (cnt_q == LEN_END) begin
          cnt_d   = '0;
          phase_d = A_OFF;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (start) begin
          cnt_d   = '0;
          phase_d = A_WAIT;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= A_OFF;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign pull = (phase_q == A_DRIVE);
  assign done = done_q;

  AST_ACK_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull) |-> $past(cnt_q) == LEN_END); // R7
  AST_ACK_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> $past(line_hi)); // R7
endmodule

// File: rtl/swire_frame_decoder.sv
module swire_frame_decoder
  import swire_pkg::*;
#(
  parameter int         T_MIN       = 4,
  parameter int         T_MAX       = 60,
  parameter int         START_MIN   = 4,
  parameter int         END_MIN     = 4,
  parameter int         ACK_DLY     = 4,
  parameter int         ACK_LEN     = 100,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'b0111_0011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       wr_valid,
  output logic [1:0] wr_addr,
  output logic [4:0] wr_data,
  output logic       ack_pull
);
  localparam int PH_MAX  = 2 * T_MAX;
  localparam int CNT_TOP = PH_MAX + START_MIN + END_MIN + 1;
  localparam int CW      = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(CNT_TOP);
  localparam logic [CW-1:0] PH_LIM  = CW'(PH_MAX);
  localparam logic [CW-1:0] ST_LIM  = CW'(START_MIN);
  localparam logic [CW-1:0] END_LIM = CW'(END_MIN);

  swire_state_e  state_q, state_d;
  logic          line_s, line_q;
  logic [CW-1:0] cnt_q, cnt_d, lo_q, lo_d;
  logic [2:0]    bits_q, bits_d;
  logic [7:0]    shreg_q, shreg_d;
  logic          hit_q, hit_d;
  logic          valid_q, valid_d;
  logic [1:0]    addr_q;
  logic [4:0]    data_q;
  logic          edge_w, rise_w, fall_w;
  logic          bit_ok, bit_val, ack_go, ack_done;

  swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  swire_bit_classify #(.W(CW), .T_MIN(T_MIN), .T_MAX(T_MAX)) u_cls (
    .lo_len(lo_q), .hi_len(cnt_q), .bit_ok(bit_ok), .bit_val(bit_val)
  );

  swire_ack_timer #(.ACK_DLY(ACK_DLY), .ACK_LEN(ACK_LEN)) u_ack (
    .clk(clk), .rst_n(rst_n), .start(ack_go), .line_hi(line_s),
    .pull(ack_pull), .done(ack_done)
  );

  assign edge_w = line_s ^ line_q;
  assign rise_w = edge_w & line_s;
  assign fall_w = edge_w & ~line_s;

  // Phase length counter: cycles the settled level has been held.
  always_comb begin
    if (edge_w)                cnt_d = CW'(1);
    else if (cnt_q == CNT_SAT) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    lo_d    = lo_q;
    bits_d  = bits_q;
    shreg_d = shreg_q;
    hit_d   = hit_q;
    valid_d = 1'b0;
    ack_go  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (fall_w && (cnt_q >= ST_LIM)) begin
          bits_d  = '0;
          state_d = S_LOW;
        end
      end
      S_LOW: begin
        if (rise_w) begin
          lo_d    = cnt_q;
          state_d = S_HIGH;
        end else if (cnt_q > PH_LIM) begin
          state_d = S_IDLE;
          hit_d   = 1'b0;
        end
      end
      S_HIGH: begin
        if (fall_w) begin
          if (bit_ok) begin
            shreg_d = {shreg_q[6:0], bit_val};
            bits_d  = bits_q + 1'b1;
            state_d = (bits_q == 3'd7) ? S_END : S_LOW;
          end else begin
            state_d = S_IDLE;
            hit_d   = 1'b0;
          end
        end else if (cnt_q > PH_LIM) begin
          state_d = S_IDLE;
          hit_d   = 1'b0;
        end
      end
      S_END: begin
        if (rise_w) begin
          state_d = S_IDLE;
          hit_d   = 1'b0;
        end else if (cnt_q >= END_LIM) begin
          state_d = S_IDLE;
          if (!hit_q) begin
            hit_d = (shreg_q == DEV_ADDR);
          end else begin
            hit_d   = 1'b0;
            valid_d = 1'b1;
            if (shreg_q[7]) begin
              ack_go  = 1'b1;
              state_d = S_ACK;
            end
          end
        end
      end
      default: begin
        if (ack_done) state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      line_q  <= 1'b1;
      cnt_q   <= '0;
      lo_q    <= '0;
      bits_q  <= '0;
      shreg_q <= '0;
      hit_q   <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      line_q  <= line_s;
      cnt_q   <= cnt_d;
      lo_q    <= lo_d;
      bits_q  <= bits_d;
      shreg_q <= shreg_d;
      hit_q   <= hit_d;
      valid_q <= valid_d;
      if (valid_d) begin
        addr_q <= shreg_q[6:5];
        data_q <= shreg_q[4:0];
      end
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R6
  AST_STROBE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(hit_q)); // R5
  AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> (state_q == S_ACK)); // R7
  AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_LOW) || (state_q == S_HIGH)) |-> (cnt_q <= PH_LIM + 1'b1)); // R4
endmodule

// File: tb/sim_swire_frame_decoder.sv
module sim_swire_frame_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int T_MIN   = 4;
  localparam int T_MAX   = 60;
  localparam int ACK_DLY = 4;
  localparam int ACK_LEN = 100;
  localparam int WD_CYC  = 190000;
  localparam logic [7:0] DEV = 8'b0111_0011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv = 1'b1;
  logic line_in;
  logic wr_valid, ack_pull;
  logic [1:0] wr_addr;
  logic [4:0] wr_data;

  int n_cmp = 0, n_bad = 0;
  int n_strobe = 0, n_ack = 0, last_ack_len = 0, ack_run = 0, early = 0, dbl = 0;
  logic [1:0] last_addr = '0;
  logic [4:0] last_data = '0;
  logic prev_v = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line_in = drv & ~ack_pull;

  swire_frame_decoder #(.T_MIN(T_MIN), .T_MAX(T_MAX), .ACK_DLY(ACK_DLY), .ACK_LEN(ACK_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack_pull(ack_pull)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        n_strobe++;
        last_addr = wr_addr;
        last_data = wr_data;
      end
      if (wr_valid && prev_v) dbl++;
      prev_v = wr_valid;
      if (ack_pull && !drv) early++;
      if (ack_pull) ack_run++;
      else if (ack_run != 0) begin
        last_ack_len = ack_run;
        n_ack++;
        ack_run = 0;
      end
    end
  end

  function automatic bit exp_strobe(logic [7:0] a);
    return a == DEV;
  endfunction
  function automatic bit exp_ack(logic [7:0] a, logic [7:0] d);
    return (a == DEV) && d[7];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic hold(logic v, int n);
    drv = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b, int s, int l);
    if (b) begin hold(1'b0, s); hold(1'b1, l); end
    else   begin hold(1'b0, l); hold(1'b1, s); end
  endtask

  // Sends the top n bits of v; s<0 picks random legal phases per bit.
  task automatic send_bits(logic [7:0] v, int n, int s, int l);
    for (int i = 7; i > 7 - n; i--) begin
      int ss, ll;
      if (s < 0) begin
        ss = T_MIN + int'($urandom % (T_MAX - T_MIN + 1));
        ll = 2 * ss + int'($urandom % (2 * T_MAX - 2 * ss + 1));
      end else begin
        ss = s; ll = l;
      end
      send_bit(v[i], ss, ll);
    end
  endtask

  task automatic settle();
    hold(1'b0, 8);
    hold(1'b1, ACK_DLY + ACK_LEN + 40);
  endtask

  task automatic frame(logic [7:0] a, logic [7:0] d, int s, int l, string req);
    int s0, a0;
    s0 = n_strobe; a0 = n_ack;
    hold(1'b1, 10);
    send_bits(a, 8, s, l);
    hold(1'b0, 8);
    hold(1'b1, 10);
    send_bits(d, 8, s, l);
    settle();
    chk((n_strobe - s0) == int'(exp_strobe(a)), req, "strobe count", n_strobe - s0, int'(exp_strobe(a)));
    if (exp_strobe(a)) begin
      chk(last_addr == d[6:5], req, "wr_addr", last_addr, d[6:5]);
      chk(last_data == d[4:0], req, "wr_data", last_data, d[4:0]);
    end
    chk((n_ack - a0) == int'(exp_ack(a, d)), "R7", "ack count", n_ack - a0, int'(exp_ack(a, d)));
    if (exp_ack(a, d))
      chk(last_ack_len == ACK_LEN, "R7", "ack length", last_ack_len, ACK_LEN);
  endtask

  // Valid address, data byte with a chosen last bit.
  task automatic bad_last(logic [7:0] d, logic lvl1, int p1, int p2, string req);
    int s0;
    s0 = n_strobe;
    hold(1'b1, 10);
    send_bits(DEV, 8, -1, 0);
    hold(1'b0, 8);
    hold(1'b1, 10);
    send_bits(d, 7, -1, 0);
    hold(lvl1 ? 1'b0 : 1'b0, p1);
    hold(1'b1, p2);
    settle();
    chk(n_strobe == s0, req, "strobe after bad bit", n_strobe - s0, 0);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0, "R1", "wr_valid in reset", wr_valid, 0);
    chk(ack_pull == 1'b0, "R1", "ack_pull in reset", ack_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(wr_valid == 1'b0 && ack_pull == 1'b0, "R1", "outputs after reset", {wr_valid, ack_pull}, 0);

    frame(DEV, 8'b1_10_10101, T_MIN, 2 * T_MIN, "R2");   // shortest legal, ratio exactly 2, ack
    frame(DEV, 8'b0_01_01010, T_MAX, 2 * T_MAX, "R6");   // longest legal phases, no ack
    bad_last(8'h26, 1'b0, 10, 19, "R3");                 // ratio just under two
    frame(DEV, 8'b0_11_00111, -1, 0, "R8");
    bad_last(8'h26, 1'b0, T_MIN - 1, 20, "R4");          // short phase too short
    bad_last(8'h26, 1'b0, 2 * T_MAX + 3, 20, "R4");      // phase too long
    frame(8'h72, 8'hC5, -1, 0, "R5");                    // wrong device code
    frame(DEV, 8'b1_00_11111, -1, 0, "R8");
    for (int k = 0; k < 18; k++) begin
      logic [7:0] a, d;
      a = ($urandom % 4 == 0) ? 8'($urandom) : DEV;
      d = 8'($urandom);
      frame(a, d, -1, 0, "R6");
    end
    chk(early == 0, "R7", "pull while line driven low", early, 0);
    chk(dbl == 0, "R6", "strobe wider than one cycle", dbl, 0);
    summary();
    $finish;
  end
endmodule